// File: doc/BRIEF.md
# Lockable NAND Page ECC Generator

This block sits beside the data path between a host bus and a NAND flash device. It folds every data word that crosses that path into a running Hamming-style parity. Reads and writes are treated alike. Two independent accumulators are kept. One covers the main data area of a page and the other covers the spare area. Each accumulator has its own lock bit, so software can freeze the main-area result once the page data has passed and then open the spare-area accumulator for the bytes that follow.

A shared initialise input clears both accumulators and their line counters. The data path is either one byte lane wide (narrow mode) or two byte lanes wide (wide mode). In wide mode every lane keeps a separate 24-bit code. Both codes are presented continuously on registered outputs.

Data words enter through a valid/ready handshake. The block only applies back-pressure in a cycle where initialise is asserted. In that cycle ready is low and the offered word is not taken. In every other cycle ready is high, and a word offered with valid is accepted on that clock edge. A word whose valid is low changes nothing.

Top module: `nand_ecc_gen`

## Requirements
- R1: `in_ready_o` is low exactly in the cycles where `ecc_init_i` is high and high otherwise. A word is accepted on a rising clock edge where both `in_valid_i` and `in_ready_o` are high.
- R2: After reset both codes read zero and both locks are set, so accepted words leave both outputs at zero until a lock is cleared.
- R3: Per lane, the 24-bit code uses two parts. Bits [17:0] are line parity: when the byte's XOR parity is 1, bit 2i+1 toggles if bit i of the line index is 1, and bit 2i toggles otherwise (i = 0..8). Bits [23:18] are column parity: bit 18+2j accumulates the XOR of the data bits whose bit position has bit j clear, and bit 19+2j accumulates those whose position has bit j set (j = 0..2). Lane 0 (data [7:0]) occupies output bits [23:0] and lane 1 (data [15:8]) occupies bits [47:24].
- R4: Each area keeps its own 9-bit line index. It starts at 0, advances by one for each word that area accumulates, and wraps from 511 to 0.
- R5: While its lock is clear, the main accumulator folds in every accepted word, and direction plays no part.
- R6: While the main lock is set, `main_ecc_o` holds its value.
- R7: The spare accumulator follows the same rules under its own lock, independently of the main lock.
- R8: Initialise clears both codes and both line indices to zero whatever the locks are. A word offered in the same cycle is not accumulated.
- R9: With `wide_mode_i` high each byte lane accumulates its own code. With it low only lane 0 accumulates, and the lane 1 code holds.
- R10: A write strobe `ctl_we_i` loads both lock bits (1 = locked). The new values govern words accepted from the next cycle on, and a word accepted in the write cycle uses the old locks.
- R11: Both outputs are registered and change only on an edge that accepts a word or initialises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode_i | input | 1 | 1: two byte lanes, 0: lane 0 only |
| ecc_init_i | input | 1 | Clear both accumulators and line indices |
| ctl_we_i | input | 1 | Load lock bits |
| ctl_main_lock_i | input | 1 | Main lock value to load (1 = locked) |
| ctl_spare_lock_i | input | 1 | Spare lock value to load (1 = locked) |
| in_valid_i | input | 1 | Data word offered |
| in_data_i | input | 16 | Data word, lane 1 in [15:8], lane 0 in [7:0] |
| in_ready_o | output | 1 | Word can be taken this cycle |
| main_ecc_o | output | 48 | Main-area code, lane 1 in [47:24], lane 0 in [23:0] |
| spare_ecc_o | output | 48 | Spare-area code, same layout |

## Verification
The assertions check the hold rules on every cycle. A locked area keeps its code, an idle lane keeps its code, and the high lane stays put in narrow mode. They also check that an accumulating area steps its line index by one and that initialise leaves zero codes behind. Only the bench scenarios can show that the code values themselves are right. Those scenarios cover the bit layout, the index wrap from 511 to 0, and the one-cycle delay of a lock write. They also cover initialise beating a same-cycle word, which is visible only as the final code.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  typedef struct packed {
    logic main;
    logic spare;
  } lock_t;

  // Mask of bit positions whose index has bit j set.
  function automatic logic [31:0] pos_mask(int j, int w);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < w; b++) m[b] = ((b >> j) & 1) != 0;
    return m;
  endfunction

endpackage

// File: rtl/ecc_lane_acc.sv
module ecc_lane_acc #(
  parameter int LANE_W = 8,
  parameter int IDX_W  = 9
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   clr_i,
  input  logic                                   en_i,
  input  logic [IDX_W-1:0]                       idx_i,
  input  logic [LANE_W-1:0]                      byte_i,
  output logic [2*IDX_W+2*$clog2(LANE_W)-1:0]    code_o
);
  import nand_ecc_pkg::*;

  localparam int CB     = $clog2(LANE_W);
  localparam int LP_W   = 2 * IDX_W;
  localparam int CODE_W = LP_W + 2 * CB;

  logic [CODE_W-1:0] code_q, delta;
  logic              par;
  logic [LANE_W-1:0] hi_mask;

  always_comb begin
    par     = ^byte_i;
    delta   = '0;
    hi_mask = '0;
    for (int i = 0; i < IDX_W; i++) begin
      delta[2*i+1] = par & idx_i[i];
      delta[2*i]   = par & ~idx_i[i];
    end
    for (int j = 0; j < CB; j++) begin
      hi_mask = LANE_W'(pos_mask(j, LANE_W));
      delta[LP_W+2*j+1] = ^(byte_i & hi_mask);
      delta[LP_W+2*j]   = ^(byte_i & ~hi_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (clr_i)  code_q <= '0;
    else if (en_i)   code_q <= code_q ^ delta;
  end

  assign code_o = code_q;

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(code_q))
    else $error("lane code moved while idle");

  p_init_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (code_q == '0))
    else $error("lane code not cleared");

endmodule

// File: rtl/ecc_area_acc.sv
module ecc_area_acc #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  parameter int IDX_W  = 9
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          clr_i,
  input  logic                                          lock_i,
  input  logic                                          take_i,
  input  logic                                          wide_i,
  input  logic [LANES*LANE_W-1:0]                       data_i,
  output logic [LANES*(2*IDX_W+2*$clog2(LANE_W))-1:0]   code_o
);
  localparam int CODE_W = 2 * IDX_W + 2 * $clog2(LANE_W);

  logic [IDX_W-1:0] idx_q;
  logic             adv;

  assign adv = take_i && !lock_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (clr_i) idx_q <= '0;
    else if (adv)   idx_q <= idx_q + IDX_W'(1);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_en;
    assign lane_en = adv && !clr_i && ((l == 0) || wide_i);
    ecc_lane_acc #(.LANE_W(LANE_W), .IDX_W(IDX_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_i),
      .en_i   (lane_en),
      .idx_i  (idx_q),
      .byte_i (data_i[l*LANE_W +: LANE_W]),
      .code_o (code_o[l*CODE_W +: CODE_W])
    );
  end

  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && !clr_i) |=> $stable(code_o))
    else $error("locked area code changed");

  p_line_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr_i) |=> (idx_q == $past(idx_q) + IDX_W'(1)))
    else $error("line index did not step");

  if (LANES > 1) begin : g_narrow_chk
    p_narrow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wide_i && !clr_i) |=> $stable(code_o[LANES*CODE_W-1:CODE_W]))
      else $error("upper lane moved in narrow mode");
  end

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen #(
  parameter int LANE_W     = 8,
  parameter int LANES      = 2,
  parameter int AREA_BYTES = 512,
  localparam int IDX_W     = $clog2(AREA_BYTES),
  localparam int CODE_W    = 2 * IDX_W + 2 * $clog2(LANE_W),
  localparam int DATA_W    = LANES * LANE_W,
  localparam int OUT_W     = LANES * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode_i,
  input  logic              ecc_init_i,
  input  logic              ctl_we_i,
  input  logic              ctl_main_lock_i,
  input  logic              ctl_spare_lock_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic [OUT_W-1:0]  main_ecc_o,
  output logic [OUT_W-1:0]  spare_ecc_o
);
  import nand_ecc_pkg::*;

  lock_t lock_q;
  logic  take;

  assign in_ready_o = !ecc_init_i;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_q <= '{main: 1'b1, spare: 1'b1};
    else if (ctl_we_i) lock_q <= '{main: ctl_main_lock_i, spare: ctl_spare_lock_i};
  end

  ecc_area_acc #(.LANE_W(LANE_W), .LANES(LANES), .IDX_W(IDX_W)) u_main (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ecc_init_i),
    .lock_i (lock_q.main),
    .take_i (take),
    .wide_i (wide_mode_i),
    .data_i (in_data_i),
    .code_o (main_ecc_o)
  );

  ecc_area_acc #(.LANE_W(LANE_W), .LANES(LANES), .IDX_W(IDX_W)) u_spare (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ecc_init_i),
    .lock_i (lock_q.spare),
    .take_i (take),
    .wide_i (wide_mode_i),
    .data_i (in_data_i),
    .code_o (spare_ecc_o)
  );

  p_init_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_init_i && in_valid_i) |=> (main_ecc_o == '0 && spare_ecc_o == '0))
    else $error("word accumulated during init");

  p_idle_outputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid_i && !ecc_init_i) |=> ($stable(main_ecc_o) && $stable(spare_ecc_o)))
    else $error("outputs moved without a word");

  p_spare_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q.spare && !ecc_init_i) |=> $stable(spare_ecc_o))
    else $error("locked spare code changed");

endmodule

// File: tb/nand_ecc_gen_tb.sv
module nand_ecc_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode_i = 1'b1, ecc_init_i = 1'b0, ctl_we_i = 1'b0;
  logic        ctl_main_lock_i = 1'b1, ctl_spare_lock_i = 1'b1, in_valid_i = 1'b0;
  logic [15:0] in_data_i = '0;
  logic        in_ready_o;
  logic [47:0] main_ecc_o, spare_ecc_o;

  int checks = 0, errors = 0;
  logic [47:0] em = '0, es = '0;
  logic [8:0]  im = '0, is_ = '0;
  logic        lm = 1'b1, ls = 1'b1;

  always #4 clk = ~clk;

  nand_ecc_gen u_dut (.*);

  // Fields: init, wide, valid, we, main_lock, spare_lock, data
  localparam logic [21:0] VEC [16] = '{
    {6'b010101, 16'h0000}, {6'b011000, 16'hA55A}, {6'b011000, 16'h0001},
    {6'b001000, 16'hFF03}, {6'b011000, 16'h8000}, {6'b011100, 16'h1234},
    {6'b011000, 16'h00F0}, {6'b010110, 16'h0000}, {6'b011000, 16'h7E81},
    {6'b111000, 16'hFFFF}, {6'b011000, 16'h0102}, {6'b010101, 16'h0000},
    {6'b001000, 16'hC3C3}, {6'b011000, 16'h0000}, {6'b011000, 16'h0080},
    {6'b000000, 16'hBEEF}
  };

  function automatic logic [23:0] lane_upd(logic [23:0] c, logic [8:0] k, logic [7:0] b);
    logic p;
    p = ^b;
    for (int i = 0; i < 9; i++)
      if (p) begin
        if (k[i]) c[2*i+1] = ~c[2*i+1];
        else      c[2*i]   = ~c[2*i];
      end
    for (int j = 0; j < 3; j++)
      for (int q = 0; q < 8; q++)
        if (b[q]) begin
          if (((q >> j) & 1) != 0) c[19+2*j] = ~c[19+2*j];
          else                     c[18+2*j] = ~c[18+2*j];
        end
    return c;
  endfunction

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model at posedge, compare at next negedge.
  task automatic step(logic init, logic wide, logic valid, logic we,
                      logic ml, logic sl, logic [15:0] d, string tag);
    ecc_init_i = init; wide_mode_i = wide; in_valid_i = valid; ctl_we_i = we;
    ctl_main_lock_i = ml; ctl_spare_lock_i = sl; in_data_i = d;
    #1 check({tag, " R1 ready"}, {47'd0, in_ready_o}, {47'd0, !init});
    @(posedge clk);
    if (init) begin
      em = '0; es = '0; im = '0; is_ = '0;
    end else if (valid) begin
      if (!lm) begin
        em[23:0] = lane_upd(em[23:0], im, d[7:0]);
        if (wide) em[47:24] = lane_upd(em[47:24], im, d[15:8]);
        im++;
      end
      if (!ls) begin
        es[23:0] = lane_upd(es[23:0], is_, d[7:0]);
        if (wide) es[47:24] = lane_upd(es[47:24], is_, d[15:8]);
        is_++;
      end
    end
    if (we) begin lm = ml; ls = sl; end
    @(negedge clk);
    in_valid_i = 1'b0; ctl_we_i = 1'b0; ecc_init_i = 1'b0;
  endtask

  task automatic send(logic wide, logic [15:0] d);
    step(1'b0, wide, 1'b1, 1'b0, 1'b0, 1'b0, d, "send");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 reset main", main_ecc_o, '0);
    check("R2 reset spare", spare_ecc_o, '0);
    check("R1 ready after reset", {47'd0, in_ready_o}, 48'd1);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h5A3C, "R2 locked");
    check("R2 locked main", main_ecc_o, '0);
    check("R2 locked spare", spare_ecc_o, '0);

    // Table walk: R3 R5 R6 R7 R8 R9 R10 R11
    for (int n = 0; n < 16; n++) begin
      step(VEC[n][21], VEC[n][20], VEC[n][19], VEC[n][18], VEC[n][17], VEC[n][16],
           VEC[n][15:0], "table");
      check($sformatf("R3/R5/R6 table %0d main", n), main_ecc_o, em);
      check($sformatf("R7/R9/R10 table %0d spare", n), spare_ecc_o, es);
    end

    // R3 literal layout: one byte 0x01 at index 0, wide mode, main only
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, "unlock");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, "init");
    send(1'b1, 16'h8001);
    check("R3 lane0 idx0 byte01", main_ecc_o[23:0], 48'h555555);
    check("R3 lane1 idx0 byte80", {24'd0, main_ecc_o[47:24]}, 48'hA95555);

    // R4 wrap: 511 zero words, then 0x01 at index 511, then 0x01 at wrapped index 0
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, "init");
    for (int n = 0; n < 511; n++) send(1'b0, 16'h0000);
    send(1'b0, 16'h0001);
    check("R4 index 511", main_ecc_o, 48'h56AAAA);
    send(1'b0, 16'h0001);
    check("R4 wrap to 0", main_ecc_o, 48'h03FFFF);

    // R11 idle cycles leave outputs alone
    repeat (4) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF, "idle");
    check("R11 idle hold", main_ecc_o, 48'h03FFFF);

    // R8 init while both locked clears, R6 lock holds across words
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0F0F, "lockboth");
    check("R6 lock-write cycle uses old lock", main_ecc_o, em);
    send(1'b1, 16'h3333);
    check("R6 main held", main_ecc_o, em);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, "init locked");
    check("R8 init main", main_ecc_o, '0);
    check("R8 init spare", spare_ecc_o, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule